// File: doc/BRIEF.md
# CPU Wait-State Generator with Watchdog Release

This block holds a host processor in a wait state while a floppy disk controller works through a transfer. The host starts the stall as a side effect of a control register write: when the written byte has its stall bit set, a wait latch is set and the active-low wait output to the processor goes low. The processor stays frozen until the controller raises its interrupt request or its data request, or until reset.

A watchdog bounds the stall so that dynamic memory refresh is never starved for long. A prescaler divides the 4 MHz system clock into a one-cycle enable at 1 MHz. That enable advances a 12-bit counter, which is held at zero whenever no wait is pending. When counter bit 10 rises, after 1024 microseconds of waiting, the wait is released even if the controller never responds. All release conditions act at the next clock edge, and a release condition takes priority over a stall write in the same cycle.

Top module: `cpuStallGen`

## Requirements
- R1: While `rst` is high, `waitN` is high (inactive) one cycle later, and a stall write during reset has no effect.
- R2: A write (`wrStrobe` high) whose data bit 6 is 1 drives `waitN` low from the next clock edge, when no release condition is present.
- R3: A write whose data bit 6 is 0 leaves `waitN` unchanged. With no wait pending, it stays high.
- R4: `intReq` high releases a pending wait: `waitN` is high one clock cycle later.
- R5: `dataReq` high releases a pending wait: `waitN` is high one clock cycle later.
- R6: When a release condition (`intReq` or `dataReq`) is high in the same cycle as a stall write, the release wins and `waitN` stays high.
- R7: With no other release condition, a wait lasts between 4094 and 4097 clock cycles. That is 1024 ticks of the 1 MHz enable (4 clocks each), plus prescaler phase and one cycle of release latency. Then `waitN` returns high by itself.
- R8: The watchdog restarts from zero for every new wait. A wait started after an early release still lasts the full R7 window.
- R9: While a wait is pending and no release condition is present, `waitN` stays low, including across further writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous active-high reset; also a release condition |
| wrStrobe | input | 1 | One-cycle write strobe of the control register |
| wrData | input | 8 | Write data; bit 6 requests a stall |
| intReq | input | 1 | Controller interrupt request, active high |
| dataReq | input | 1 | Controller data request, active high |
| waitN | output | 1 | Active-low wait to the processor |

## Verification
A wrong latch state shows at once on `waitN`, one edge after the write or release that should have moved it. The checks sample exactly that cycle. A watchdog counter that is not cleared between waits, that runs during idle, or that uses the wrong tap shows only as a stall of the wrong length. The bench therefore times full stalls against the 4094 to 4097 cycle window, from several prescaler phases and after an early release. This takes about 4100 cycles per measurement.

// File: rtl/stallPkg.sv
package stallPkg;
  // Strobes from the latch control into the watchdog datapath
  typedef struct packed {
    logic cntRun;  // a wait is pending: counter may advance on a tick
    logic cntClr;  // force the counter back to zero
  } cntStrobeT;
endpackage

// File: rtl/stallTimer.sv
module stallTimer
  import stallPkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int CNT_W       = 12,
  parameter int TIMEOUT_BIT = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  cntStrobeT strobe,
  output logic      timeoutHit
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick;

  // Prescaler: one-cycle enable every TICK_DIV clocks, free running
  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (rst || preCnt == PRE_LAST) preCnt <= '0;
        else                          preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_LAST);
    end else begin : g_noprescale
      assign tick = 1'b1;
    end
  endgenerate

  // Watchdog counter, advanced only while a wait is pending
  logic [CNT_W-1:0] dogCnt;
  always_ff @(posedge clk) begin
    if (rst || strobe.cntClr)       dogCnt <= '0;
    else if (strobe.cntRun && tick) dogCnt <= dogCnt + 1'b1;
  end

  assign timeoutHit = dogCnt[TIMEOUT_BIT];
endmodule

// File: rtl/stallCtrl.sv
module stallCtrl
  import stallPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intReq,
  input  logic              dataReq,
  input  logic              timeoutHit,
  output cntStrobeT         strobe,
  output logic              pending
);
  logic clearNow;
  logic setReq;

  assign clearNow = rst | intReq | dataReq | timeoutHit;
  assign setReq   = wrStrobe & wrData[SEL_BIT];

  // Wait latch: any release condition beats a set in the same cycle
  always_ff @(posedge clk) begin
    if (clearNow)    pending <= 1'b0;
    else if (setReq) pending <= 1'b1;
  end

  always_comb begin
    strobe.cntRun = pending;
    strobe.cntClr = clearNow | ~pending;
  end
endmodule

// File: rtl/cpuStallGen.sv
module cpuStallGen
  import stallPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_BIT     = 6,
  parameter int TICK_DIV    = 4,
  parameter int CNT_W       = 12,
  parameter int TIMEOUT_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intReq,
  input  logic              dataReq,
  output logic              waitN
);
  cntStrobeT strobe;
  logic      timeoutHit;
  logic      pending;

  stallCtrl #(.DATA_W(DATA_W), .SEL_BIT(SEL_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData),
    .intReq(intReq), .dataReq(dataReq), .timeoutHit(timeoutHit),
    .strobe(strobe), .pending(pending)
  );

  stallTimer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .TIMEOUT_BIT(TIMEOUT_BIT)) u_timer (
    .clk(clk), .rst(rst), .strobe(strobe), .timeoutHit(timeoutHit)
  );

  assign waitN = ~pending;
endmodule

// File: rtl/cpuStallGenChk.sv
module cpuStallGenChk #(
  parameter int DATA_W      = 8,
  parameter int SEL_BIT     = 6,
  parameter int TICK_DIV    = 4,
  parameter int TIMEOUT_BIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wrStrobe,
  input logic [DATA_W-1:0] wrData,
  input logic              intReq,
  input logic              dataReq,
  input logic              timeoutHit,
  input logic              waitN
);
  localparam int MAX_LOW = TICK_DIV * (2 ** TIMEOUT_BIT) + 1;

  logic prevRst;
  int   lowCnt;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (rst || waitN) lowCnt <= 0;
    else              lowCnt <= lowCnt + 1;
  end

  always @(negedge clk) begin
    if (prevRst === 1'b1) assert_reset_idle_R1: assert (waitN);
    if (prevRst === 1'b0) assert_window_R7: assert (lowCnt <= MAX_LOW);
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (waitN && wrStrobe && wrData[SEL_BIT] && !intReq && !dataReq) |=> !waitN);

  assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (waitN && !(wrStrobe && wrData[SEL_BIT])) |=> waitN);

  assert_irq_release_R4: assert property (@(posedge clk) disable iff (rst)
    intReq |=> waitN);

  assert_drq_release_R5: assert property (@(posedge clk) disable iff (rst)
    dataReq |=> waitN);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && wrData[SEL_BIT] && (intReq || dataReq)) |=> waitN);

  assert_timeout_release_R7: assert property (@(posedge clk) disable iff (rst)
    timeoutHit |=> waitN);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!waitN && !intReq && !dataReq && !timeoutHit) |=> !waitN);
endmodule

bind cpuStallGen cpuStallGenChk #(
  .DATA_W(DATA_W), .SEL_BIT(SEL_BIT), .TICK_DIV(TICK_DIV), .TIMEOUT_BIT(TIMEOUT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData),
  .intReq(intReq), .dataReq(dataReq), .timeoutHit(timeoutHit), .waitN(waitN)
);

// File: tb/test_cpuStallGen.sv
`timescale 1ns/1ps
module test_cpuStallGen;
  localparam int WIN_LO = 4094;
  localparam int WIN_HI = 4097;

  logic       clk = 1'b0;
  logic       rst;
  logic       wrStrobe;
  logic [7:0] wrData;
  logic       intReq;
  logic       dataReq;
  logic       waitN;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpuStallGen i_cpuStallGen (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData),
    .intReq(intReq), .dataReq(dataReq), .waitN(waitN)
  );

  // expected latch state from the requirements: release beats set
  function automatic bit nextPending(bit cur, bit wr, logic [7:0] d, bit irq, bit drq);
    if (irq || drq) return 1'b0;
    if (wr && d[6]) return 1'b1;
    return cur;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic checkBit(string tag, logic actual, logic expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s: waitN got %0b expected %0b", tag, actual, expected);
    end
  endtask

  task automatic checkRange(string tag, int actual);
    testsRun++;
    if (actual < WIN_LO || actual > WIN_HI) begin
      testsFailed++;
      $display("FAIL %s: wait length got %0d expected %0d..%0d", tag, actual, WIN_LO, WIN_HI);
    end
  endtask

  task automatic idle();
    wrStrobe = 0; wrData = 8'h00; intReq = 0; dataReq = 0;
  endtask

  task automatic startWait(logic [7:0] d);
    wrStrobe = 1; wrData = d;
    step();
    wrStrobe = 0; wrData = 8'h00;
  endtask

  task automatic measureWait(string tag);
    int len = 0;
    startWait(8'h40);
    while (waitN == 1'b0 && len < 6000) begin
      len++;
      step();
    end
    checkRange(tag, len);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: run hung, got 0 expected 1 completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    bit pend;
    int age;
    idle();
    rst = 1;
    step(); step(); step();
    checkBit("R1 reset idle", waitN, 1'b1);
    startWait(8'h40);               // stall write while reset held
    checkBit("R1 write during reset", waitN, 1'b1);
    rst = 0;
    step();
    checkBit("R1 after reset", waitN, 1'b1);

    // R3: write without bit 6
    wrStrobe = 1; wrData = 8'hBF; step(); idle();
    checkBit("R3 bit6 clear ignored", waitN, 1'b1);

    // R2: set
    startWait(8'h40);
    checkBit("R2 set", waitN, 1'b0);
    // R9: hold across writes
    for (int i = 0; i < 5; i++) begin
      wrStrobe = 1; wrData = 8'(i * 37); step(); idle();
      checkBit("R9 hold", waitN, 1'b0);
    end
    // R4
    intReq = 1; step(); idle();
    checkBit("R4 irq release", waitN, 1'b1);

    startWait(8'hFF);
    checkBit("R2 set all bits", waitN, 1'b0);
    dataReq = 1; step(); idle();
    checkBit("R5 drq release", waitN, 1'b1);

    // R6
    wrStrobe = 1; wrData = 8'h40; intReq = 1; step(); idle();
    checkBit("R6 irq beats set", waitN, 1'b1);
    wrStrobe = 1; wrData = 8'h40; dataReq = 1; step(); idle();
    checkBit("R6 drq beats set", waitN, 1'b1);

    // R1: reset releases a pending wait
    startWait(8'h40);
    rst = 1; step(); rst = 0;
    checkBit("R1 reset releases", waitN, 1'b1);

    // R7: timeout from several prescaler phases
    for (int ofs = 0; ofs < 4; ofs++) begin
      for (int k = 0; k < ofs; k++) step();
      measureWait("R7 watchdog window");
    end

    // R8: early release then a fresh full window
    startWait(8'h40);
    for (int k = 0; k < 700; k++) step();
    checkBit("R8 still pending", waitN, 1'b0);
    intReq = 1; step(); idle();
    checkBit("R8 early release", waitN, 1'b1);
    measureWait("R8 watchdog restarts");

    // constrained random against the bench model
    void'($urandom(32'd1234));
    pend = 1'b0; age = 0;
    for (int i = 0; i < 3000; i++) begin
      wrStrobe = ($urandom % 6) == 0;
      wrData   = 8'($urandom);
      intReq   = ($urandom % 20) == 0;
      dataReq  = ($urandom % 20) == 0;
      if (age > 1500) intReq = 1;   // keep the watchdog out of the random run
      pend = nextPending(pend, wrStrobe, wrData, intReq, dataReq);
      age  = pend ? age + 1 : 0;
      step();
      checkBit("R2/R3/R4/R5/R6/R9 random", waitN, ~pend);
    end
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule